// File: doc/BRIEF.md
# Routed Multi-Core Interrupt Controller

The block gathers up to 32 device interrupt lines and steers each of them to one interrupt pin on one of four processor cores, which gives 16 upstream request lines. Software sets the active level and the trigger kind of each source, reads which sources are pending, enables or disables sources through separate set and clear words, and picks the destination of each source with one route byte per source.

Raw inputs are synchronized, adjusted for polarity and then either followed (level mode) or captured on their rising edge (edge mode). A captured edge stays pending until software writes a 1 to the source's bit in the clear word, which also disables the source. Each upstream line is the registered OR of every source that is pending, enabled and routed to that core and pin. A simple synchronous register port gives byte access to the route table and 32-bit access to the control words, with read data returned one cycle after the request.

Top module: `irq_router`

## Requirements
- R1: After reset the enable, polarity, trigger and route registers and all latched edges are zero, and every `irq_o` bit is low.
- R2: Route bytes sit at offsets 0x00 to 0x1F, one per source (source n at offset n), written from and read back on data bits 7:0. Bits 7:4 select the pin one-hot (bit 4+p for pin p) and bits 3:0 select the core one-hot (bit c for core c).
- R3: `irq_o[c*4+p]` is the OR of all sources that are pending, enabled and whose route byte has core bit c and pin bit p set; a route byte without a core bit or without a pin bit drives no output, and with no source enabled every output is low.
- R4: The enable word reads at 0x24 and ignores writes there; writing 0x28 sets each enable bit whose data bit is 1 and leaves the others unchanged.
- R5: Writing 0x2C disables each source whose data bit is 1 and clears its latched edge; 0 bits have no effect.
- R6: Polarity word at 0x30: bit n = 1 makes source n active high, 0 active low.
- R7: Trigger word at 0x34: bit n = 0 makes source n pending while its adjusted input is active; 1 latches a rising edge of the adjusted input, which then stays pending after the input returns inactive until cleared through 0x2C.
- R8: The pending word reads at 0x20 with bit n for source n; writes to 0x20 are ignored.
- R9: Reads of write-only offsets (0x28, 0x2C), of route offsets beyond the source count and of any other unmapped offset return zero.
- R10: A level-mode source change reaches `irq_o` on the third rising clock edge after it is applied; an edge-mode rising edge reaches it on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_raw_i | input | 32 | Raw device interrupt lines, asynchronous |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 16 | Upstream request lines, index core*4+pin |

## Verification
On every cycle the assertions check that set and clear writes land on exactly the addressed enable bits, that a latched edge only drops after a clear write, that unmapped reads return zero, that no output is raised while all sources are disabled, and that outputs are low in reset. Polarity, the exact input-to-output latency, routing to the right core and pin, suppression by an incomplete route byte and the OR of several sources on one line depend on chosen stimulus and are shown only by the bench's scenarios.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_PEND = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_EN   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_SET  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_POL  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_TRIG = 8'h34;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ROUTE, SEL_PEND, SEL_EN, SEL_SET, SEL_CLR, SEL_POL, SEL_TRIG
  } reg_sel_e;
endpackage

// File: rtl/irq_src_cond.sv
`timescale 1ns/1ps
module irq_src_cond #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] meta_q, sync_q, prev_q, latch_q, adj;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  // active when synced level matches selected polarity
  assign adj = ~(sync_q ^ pol_i);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    // prev resets high so an active-low idle line is not seen as an edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[s]  <= 1'b1;
        latch_q[s] <= 1'b0;
      end else begin
        prev_q[s] <= adj[s];
        if (trig_i[s] && adj[s] && !prev_q[s]) latch_q[s] <= 1'b1;
        else if (clr_i[s])                     latch_q[s] <= 1'b0;
      end
    end
    assign pend_o[s] = trig_i[s] ? latch_q[s] : adj[s];
  end
endmodule

// File: rtl/irq_regfile.sv
`timescale 1ns/1ps
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ROUTE_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  input  logic [NUM_SRC-1:0]               pend_i,
  output logic [NUM_SRC-1:0]               en_o,
  output logic [NUM_SRC-1:0]               pol_o,
  output logic [NUM_SRC-1:0]               trig_o,
  output logic [NUM_SRC-1:0]               clr_o,
  output logic [NUM_SRC-1:0][ROUTE_W-1:0]  route_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  reg_sel_e            sel;
  logic                wr, rd;
  logic [IDX_W-1:0]    idx;
  logic [NUM_SRC-1:0]  wbits;
  logic [DATA_W-1:0]   rmux;
  logic [NUM_SRC-1:0]  en_q, pol_q, trig_q;
  logic [NUM_SRC-1:0][ROUTE_W-1:0] route_q;

  always_comb begin
    if (32'(addr_i) < NUM_SRC) sel = SEL_ROUTE;
    else begin
      case (addr_i)
        OFF_PEND: sel = SEL_PEND;
        OFF_EN:   sel = SEL_EN;
        OFF_SET:  sel = SEL_SET;
        OFF_CLR:  sel = SEL_CLR;
        OFF_POL:  sel = SEL_POL;
        OFF_TRIG: sel = SEL_TRIG;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign idx   = addr_i[IDX_W-1:0];
  assign wbits = wdata_i[NUM_SRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      pol_q   <= '0;
      trig_q  <= '0;
      route_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_ROUTE: route_q[idx] <= wdata_i[ROUTE_W-1:0];
        SEL_SET:   en_q   <= en_q | wbits;
        SEL_CLR:   en_q   <= en_q & ~wbits;
        SEL_POL:   pol_q  <= wbits;
        SEL_TRIG:  trig_q <= wbits;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr && sel == SEL_CLR) ? wbits : '0;

  always_comb begin
    rmux = '0;
    case (sel)
      SEL_ROUTE: rmux[ROUTE_W-1:0] = route_q[idx];
      SEL_PEND:  rmux[NUM_SRC-1:0] = pend_i;
      SEL_EN:    rmux[NUM_SRC-1:0] = en_q;
      SEL_POL:   rmux[NUM_SRC-1:0] = pol_q;
      SEL_TRIG:  rmux[NUM_SRC-1:0] = trig_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rmux;
  end

  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
  assign route_o = route_q;
endmodule

// File: rtl/irq_route_matrix.sv
`timescale 1ns/1ps
module irq_route_matrix #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 4,
  localparam int ROUTE_W = NUM_CORE + NUM_PIN,
  localparam int NUM_OUT = NUM_CORE * NUM_PIN
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_SRC-1:0]               pend_i,
  input  logic [NUM_SRC-1:0]               en_i,
  input  logic [NUM_SRC-1:0][ROUTE_W-1:0]  route_i,
  output logic [NUM_OUT-1:0]               irq_o
);
  logic [NUM_SRC-1:0] live;
  logic [NUM_OUT-1:0] hit;

  assign live = pend_i & en_i;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic [NUM_SRC-1:0] sel;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign sel[s] = live[s] & route_i[s][c] & route_i[s][NUM_CORE+p];
      end
      assign hit[c*NUM_PIN+p] = |sel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= hit;
  end
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 4,
  localparam int ROUTE_W = NUM_CORE + NUM_PIN,
  localparam int NUM_OUT = NUM_CORE * NUM_PIN
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   irq_raw_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_OUT-1:0]   irq_o
);
  logic [NUM_SRC-1:0] en_w, pol_w, trig_w, clr_w, pend_w;
  logic [NUM_SRC-1:0][ROUTE_W-1:0] route_w;

  irq_src_cond #(.NUM_SRC(NUM_SRC)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (irq_raw_i),
    .pol_i  (pol_w),
    .trig_i (trig_w),
    .clr_i  (clr_w),
    .pend_o (pend_w)
  );

  irq_regfile #(.NUM_SRC(NUM_SRC), .ROUTE_W(ROUTE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pend_i  (pend_w),
    .en_o    (en_w),
    .pol_o   (pol_w),
    .trig_o  (trig_w),
    .clr_o   (clr_w),
    .route_o (route_w)
  );

  irq_route_matrix #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_matrix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend_w),
    .en_i    (en_w),
    .route_i (route_w),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_OUT = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_OUT-1:0] irq_o,
  input logic [NUM_SRC-1:0] en_w,
  input logic [NUM_SRC-1:0] pend_w,
  input logic [NUM_SRC-1:0] trig_w
);
  logic wr_set, wr_clr, rd_unmapped;
  logic [NUM_SRC-1:0] clr_mask;

  assign wr_set = req_i & we_i & (addr_i == OFF_SET);
  assign wr_clr = req_i & we_i & (addr_i == OFF_CLR);
  assign clr_mask = wr_clr ? wdata_i[NUM_SRC-1:0] : '0;
  assign rd_unmapped = req_i & ~we_i & (32'(addr_i) >= NUM_SRC) &
                       addr_i != OFF_PEND & addr_i != OFF_EN &
                       addr_i != OFF_POL & addr_i != OFF_TRIG;

  always @(posedge clk_i)
    if (!rst_ni) p_reset_quiet_r1: assert (irq_o == '0);

  p_set_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> (en_w & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0]));

  p_clr_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> (en_w & $past(wdata_i[NUM_SRC-1:0])) == '0);

  p_edge_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(pend_w & trig_w & ~clr_mask) & trig_w & ~pend_w) == '0);

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unmapped |=> rdata_o == '0);

  p_no_enable_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_w == '0 |=> irq_o == '0);
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .en_w    (en_w),
  .pend_w  (pend_w),
  .trig_w  (trig_w)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_raw_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] pol_sh = '0;
  logic [31:0] trig_sh = '0;

  always #10 clk_i = ~clk_i;

  irq_router u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_raw_i(irq_raw_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
    d = rdata_o;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cleanup();
    wr(8'h2C, 32'hFFFF_FFFF);
    cyc(3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    rd(8'h24, d); chk("R1 enable reset", d, 0);
    rd(8'h30, d); chk("R1 polarity reset", d, 0);
    rd(8'h34, d); chk("R1 trigger reset", d, 0);
    rd(8'h05, d); chk("R1 route reset", d, 0);
  endtask

  task automatic t_route_rw();
    logic [31:0] d;
    wr(8'h05, 32'hFFFF_FF24);
    wr(8'h1F, 32'h0000_0081);
    rd(8'h05, d); chk("R2 route byte 5", d, 32'h24);
    rd(8'h1F, d); chk("R2 route byte 31", d, 32'h81);
    rd(8'h04, d); chk("R2 neighbour byte untouched", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h28, 32'hA0);
    rd(8'h24, d); chk("R4 set enables", d, 32'hA0);
    wr(8'h28, 32'h01);
    rd(8'h24, d); chk("R4 set keeps others", d, 32'hA1);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, d); chk("R4 enable word read-only", d, 32'hA1);
    wr(8'h2C, 32'h80);
    rd(8'h24, d); chk("R5 clear selected enable", d, 32'h21);
    cleanup();
    rd(8'h24, d); chk("R5 clear all", d, 0);
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    pol_sh[5] = 1; wr(8'h30, pol_sh);
    rd(8'h30, d); chk("R6 polarity readback", d, pol_sh);
    wr(8'h28, 32'h1 << 5);
    cyc(3);
    chk("R3 inactive level source", 32'(irq_o), 0);
    irq_raw_i[5] = 1;
    cyc(2); chk("R10 level not yet at edge 2", 32'(irq_o[9]), 0);
    cyc(1); chk("R10 level at edge 3", 32'(irq_o), 32'h200);
    rd(8'h20, d); chk("R8 pending bit 5", 32'(d[5]), 1);
    irq_raw_i[5] = 0;
    cyc(3); chk("R7 level follows input low", 32'(irq_o), 0);
    cleanup();
  endtask

  task automatic t_level_low();
    wr(8'h07, 32'h11);
    wr(8'h28, 32'h1 << 7);
    cyc(3); chk("R6 active-low idle line pending", 32'(irq_o), 32'h1);
    irq_raw_i[7] = 1;
    cyc(4); chk("R6 active-low line released", 32'(irq_o), 0);
    cleanup();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    pol_sh[12] = 1;  wr(8'h30, pol_sh);
    trig_sh[12] = 1; wr(8'h34, trig_sh);
    wr(8'h0C, 32'h88);
    wr(8'h28, 32'h1 << 12);
    cyc(3); chk("R7 edge idle", 32'(irq_o), 0);
    irq_raw_i[12] = 1;
    cyc(3); chk("R10 edge not yet at edge 3", 32'(irq_o[15]), 0);
    cyc(1); chk("R10 edge at edge 4", 32'(irq_o), 32'h8000);
    irq_raw_i[12] = 0;
    cyc(8); chk("R7 edge stays latched", 32'(irq_o), 32'h8000);
    rd(8'h20, d); chk("R8 latched pending bit 12", 32'(d[12]), 1);
    wr(8'h2C, 32'h1 << 12);
    cyc(1); chk("R5 clear drops output", 32'(irq_o), 0);
    wr(8'h28, 32'h1 << 12);
    cyc(3); chk("R5 latched edge cleared", 32'(irq_o), 0);
    rd(8'h20, d); chk("R5 pending bit 12 cleared", 32'(d[12]), 0);
    cleanup();
  endtask

  task automatic t_route_gaps();
    pol_sh[20] = 1; wr(8'h30, pol_sh);
    wr(8'h14, 32'h10);
    wr(8'h28, 32'h1 << 20);
    irq_raw_i[20] = 1;
    cyc(5); chk("R3 no core bit drives nothing", 32'(irq_o), 0);
    wr(8'h14, 32'h01);
    cyc(2); chk("R3 no pin bit drives nothing", 32'(irq_o), 0);
    wr(8'h14, 32'h24);
    cyc(2); chk("R3 routed to core2 pin1", 32'(irq_o), 32'h200);
    wr(8'h28, 32'h1 << 5);
    irq_raw_i[20] = 0; irq_raw_i[5] = 1;
    cyc(2); chk("R3 OR of sources on one line", 32'(irq_o), 32'h200);
    cyc(3); chk("R3 second source alone", 32'(irq_o), 32'h200);
    irq_raw_i[5] = 0;
    cleanup();
  endtask

  task automatic t_unmapped();
    logic [31:0] a, b;
    rd(8'h20, a);
    wr(8'h20, ~a);
    rd(8'h20, b); chk("R8 pending word ignores writes", b, a);
    rd(8'h28, b); chk("R9 set word reads zero", b, 0);
    rd(8'h2C, b); chk("R9 clear word reads zero", b, 0);
    rd(8'h3C, b); chk("R9 unmapped 0x3C", b, 0);
    rd(8'hFC, b); chk("R9 unmapped 0xFC", b, 0);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(1);
    t_reset();
    t_route_rw();
    t_enable();
    t_level_high();
    t_level_low();
    t_edge();
    t_route_gaps();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule